// File: doc/BRIEF.md
# Masked Repeating Alarm Comparator

This block keeps four alarm set-points, for seconds, minutes, hours and day of month, each one a BCD byte whose top bit is a mask. A separate clock counter supplies the live BCD time fields and a one-cycle strobe once per second. On every strobe the block compares the unmasked alarm fields with the live fields. When they agree it emits a one-cycle interrupt pulse and sets a sticky alarm flag.

The masks are read as a ladder from the date field downward, and that ladder picks how often the alarm repeats. With no mask set the alarm is monthly. With the date masked it is daily. With date and hour masked it is hourly. With date, hour and minute masked it fires once a minute. Any other mask combination makes it fire on every strobe. A write that carries a field value out of range is dropped, so the stored set-point always holds a legal time. Software clears the flag through a dedicated read-acknowledge strobe.

Top module: `masked_alarm_cmp`

## Requirements
- R1: After reset all four alarm registers read 0x00, `irq` is 0 and `alarm_flag` is 0. Because the date register then holds 00, the alarm cannot fire until a valid date is written.
- R2: The write address selects the field: 0 is seconds, 1 is minutes, 2 is hours, 3 is date. A seconds or minutes write is stored, all 8 bits, only when bits 6:0 form valid BCD (both nibbles at most 9) with a value from 00 to 59. Otherwise the register keeps its old value.
- R3: An hours write is stored only when bits 5:0 are valid BCD from 00 to 23. A date write is stored only when bits 5:0 are valid BCD from 01 to 31. Bits 7 and 6 are stored as written.
- R4: With none of the four masks set (bit 7 of each register is 0), a strobe fires only when seconds bits 6:0, minutes bits 6:0, hours bits 5:0 and date bits 5:0 all equal the live fields.
- R5: With only the date mask set, a strobe fires when seconds, minutes and hours match, whatever the live date.
- R6: With only the date and hour masks set, a strobe fires when seconds and minutes match.
- R7: With only the date, hour and minute masks set, a strobe fires when seconds match.
- R8: Any mask pattern other than those in R4 to R7 makes every strobe fire.
- R9: `irq` is high for exactly the one clock cycle after the edge that sampled a firing strobe. It is never high without a strobe on the previous edge.
- R10: `alarm_flag` goes to 1 together with `irq`. It stays at 1 until `flag_rd` is sampled high, which clears it. A firing strobe in the same cycle as `flag_rd` leaves the flag at 1.
- R11: `rd_data` shows, combinationally, the alarm register selected by `rd_addr`, using the same address map as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Alarm register write strobe |
| wr_addr | input | 2 | Alarm register write select |
| wr_data | input | 8 | Write data, bit 7 is the mask |
| rd_addr | input | 2 | Alarm register read select |
| rd_data | output | 8 | Selected alarm register contents |
| flag_rd | input | 1 | Flag read acknowledge, clears the flag |
| tick | input | 1 | One-second strobe, one cycle wide |
| now_sec | input | 8 | Live seconds, BCD |
| now_min | input | 8 | Live minutes, BCD |
| now_hour | input | 8 | Live hours, BCD |
| now_date | input | 8 | Live day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The bench works through each rung of the mask ladder. At each rung it sends one strobe where only the masked field differs, which must fire, and one where an unmasked field differs, which must stay quiet. A rate decoder that shifted a rung would either miss the first strobe or fire on the second. Writes at the edges of each range (60, a non-decimal digit, 24, date 00 and 32) are read back. A validator that was off by one, or that skipped the digit check, would leave a corrupted set-point in place. The bench also checks that the interrupt falls after one cycle, and that a flag acknowledge arriving together with a firing strobe does not lose the new event.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NFIELD = 4;
  localparam int DW     = 8;
  localparam int AW     = $clog2(NFIELD);

  typedef enum logic [2:0] {
    RATE_MONTH, RATE_DAY, RATE_HOUR, RATE_MIN, RATE_SEC
  } rate_e;

  // Binary value of a two-digit BCD byte
  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic logic bcd_in_range(input logic [7:0] v,
                                        input logic [6:0] lo,
                                        input logic [6:0] hi);
    logic [6:0] b;
    b = bcd_to_bin(v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (b >= lo) && (b <= hi);
  endfunction

  // Value bits taking part in validation and comparison, per field
  function automatic logic [7:0] field_bits(input int unsigned idx);
    return (idx < 2) ? 8'h7F : 8'h3F;
  endfunction

  function automatic logic field_ok(input int unsigned idx, input logic [7:0] d);
    logic [7:0] v;
    v = d & field_bits(idx);
    case (idx)
      0, 1:    return bcd_in_range(v, 7'd0, 7'd59);
      2:       return bcd_in_range(v, 7'd0, 7'd23);
      default: return bcd_in_range(v, 7'd1, 7'd31);
    endcase
  endfunction

  // mask bits: [0] sec, [1] min, [2] hour, [3] date
  function automatic rate_e decode_rate(input logic [3:0] m);
    case (m)
      4'b0000: return RATE_MONTH;
      4'b1000: return RATE_DAY;
      4'b1100: return RATE_HOUR;
      4'b1110: return RATE_MIN;
      default: return RATE_SEC;
    endcase
  endfunction

  // Fields that must equal the live time for a given rate
  function automatic logic [3:0] fields_compared(input rate_e r);
    case (r)
      RATE_MONTH: return 4'b1111;
      RATE_DAY:   return 4'b0111;
      RATE_HOUR:  return 4'b0011;
      RATE_MIN:   return 4'b0001;
      default:    return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  output logic [NFIELD-1:0][DW-1:0] regs
);
  logic [NFIELD-1:0] hit;
  logic [NFIELD-1:0] accept;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign hit[i]    = wr_en && (wr_addr == AW'(i));
    assign accept[i] = hit[i] && field_ok(i, wr_data);

    always_ff @(posedge clk) begin
      if (!rst_n)         regs[i] <= RST_VAL;
      else if (accept[i]) regs[i] <= wr_data;
    end

    // R2/R3: an out-of-range write leaves the register untouched
    assert_reject_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !accept[i]) |=> $stable(regs[i]));
    // R3: an accepted write lands exactly
    assert_accept_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept[i] |=> (regs[i] == $past(wr_data)));
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic [NFIELD-1:0][DW-1:0] regs,
  input  logic [NFIELD-1:0][DW-1:0] live,
  output rate_e                     rate,
  output logic [NFIELD-1:0]         field_eq,
  output logic                      hit_now
);
  logic [NFIELD-1:0] masks;
  logic [NFIELD-1:0] need;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign masks[i]    = regs[i][DW-1];
    assign field_eq[i] = ((regs[i] ^ live[i]) & field_bits(i)) == '0;
  end

  assign rate    = decode_rate(masks);
  assign need    = fields_compared(rate);
  assign hit_now = &(field_eq | ~need);
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit_now,
  input  logic flag_rd,
  output logic irq,
  output logic flag
);
  logic fire;
  assign fire = tick && hit_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      flag <= 1'b0;
    end else begin
      irq  <= fire;
      flag <= fire || (flag && !flag_rd);
    end
  end

  // R9: a pulse only follows a strobe
  assert_irq_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));
  // R10: flag accompanies every pulse
  assert_flag_with_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  // R10: acknowledge clears when no new event
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !fire) |=> !flag);
endmodule

// File: rtl/masked_alarm_cmp.sv
module masked_alarm_cmp
  import alarm_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       flag_rd,
  input  logic       tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  output logic       irq,
  output logic       alarm_flag
);
  logic [NFIELD-1:0][DW-1:0] regs;
  logic [NFIELD-1:0][DW-1:0] live;
  logic [NFIELD-1:0]         field_eq;
  rate_e                     rate;
  logic                      hit_now;

  assign live = {now_date, now_hour, now_min, now_sec};

  alarm_regfile #(.RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs(regs)
  );

  alarm_match u_match (
    .regs(regs), .live(live), .rate(rate), .field_eq(field_eq), .hit_now(hit_now)
  );

  alarm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hit_now(hit_now),
    .flag_rd(flag_rd), .irq(irq), .flag(alarm_flag)
  );

  assign rd_data = regs[rd_addr];

  // R8: free-running rate fires on every strobe
  assert_every_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate == RATE_SEC) |=> irq);
  // R4: monthly rate needs the date to agree
  assert_month_date_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate == RATE_MONTH && !field_eq[3]) |=> !irq);
  // R7: per-minute rate needs the seconds to agree
  assert_minute_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate == RATE_MIN && !field_eq[0]) |=> !irq);
endmodule

// File: tb/sim_masked_alarm_cmp.sv
module sim_masked_alarm_cmp;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, wr_en = 1'b0, flag_rd = 1'b0, tick = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
  logic       irq, alarm_flag;

  masked_alarm_cmp u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag_rd(flag_rd), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
    .irq(irq), .alarm_flag(alarm_flag)
  );

  int    checks = 0, errors = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard for the interrupt output
  initial forever begin
    @(posedge clk); #1;
    if (exp_q.size() > 0) begin
      bit e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(irq == e, t, irq, e);
    end else if (rst_n && irq) begin
      chk(1'b0, "R9 stray pulse", irq, 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); rd_addr = a; #1;
    chk(rd_data == e, tag, rd_data, e);
  endtask

  task automatic tick_at(input logic [7:0] s, m, h, d, input bit e, input string tag);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = d; tick = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic flag_chk(input bit e, input string tag);
    @(negedge clk);
    chk(alarm_flag == e, tag, alarm_flag, e);
  endtask

  task automatic flag_ack();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    chk(alarm_flag == 1'b0, "R1 flag in reset", alarm_flag, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) rd_chk(2'(i), 8'h00, "R1 reset register");
    tick_at(8'h00, 8'h00, 8'h00, 8'h01, 1'b0, "R1 no fire after reset");

    // set-point 25th 12:15:30
    wr(2'd0, 8'h30); wr(2'd1, 8'h15); wr(2'd2, 8'h12); wr(2'd3, 8'h25);
    rd_chk(2'd0, 8'h30, "R11 read seconds");
    rd_chk(2'd3, 8'h25, "R11 read date");

    // range checks
    wr(2'd0, 8'h60); rd_chk(2'd0, 8'h30, "R2 seconds 60 rejected");
    wr(2'd0, 8'h3A); rd_chk(2'd0, 8'h30, "R2 non-decimal digit rejected");
    wr(2'd1, 8'h59); rd_chk(2'd1, 8'h59, "R2 minutes 59 accepted");
    wr(2'd1, 8'h15);
    wr(2'd2, 8'h24); rd_chk(2'd2, 8'h12, "R3 hour 24 rejected");
    wr(2'd2, 8'h23); rd_chk(2'd2, 8'h23, "R3 hour 23 accepted");
    wr(2'd2, 8'h12);
    wr(2'd3, 8'h00); rd_chk(2'd3, 8'h25, "R3 date 00 rejected");
    wr(2'd3, 8'h32); rd_chk(2'd3, 8'h25, "R3 date 32 rejected");

    // monthly
    tick_at(8'h30, 8'h15, 8'h12, 8'h25, 1'b1, "R4 monthly match");
    flag_chk(1'b1, "R10 flag set");
    tick_at(8'h30, 8'h15, 8'h12, 8'h24, 1'b0, "R4 date differs");
    flag_chk(1'b1, "R10 flag held");
    flag_ack();
    flag_chk(1'b0, "R10 flag cleared");
    tick_at(8'h31, 8'h15, 8'h12, 8'h25, 1'b0, "R4 seconds differ");

    // daily
    wr(2'd3, 8'hA5);
    tick_at(8'h30, 8'h15, 8'h12, 8'h03, 1'b1, "R5 daily any date");
    tick_at(8'h30, 8'h15, 8'h13, 8'h25, 1'b0, "R5 hour differs");

    // hourly
    wr(2'd2, 8'h92);
    tick_at(8'h30, 8'h15, 8'h07, 8'h09, 1'b1, "R6 hourly any hour");
    tick_at(8'h30, 8'h16, 8'h12, 8'h25, 1'b0, "R6 minute differs");

    // per minute
    wr(2'd1, 8'h95);
    tick_at(8'h30, 8'h44, 8'h01, 8'h17, 1'b1, "R7 minute any");
    tick_at(8'h31, 8'h15, 8'h12, 8'h25, 1'b0, "R7 seconds differ");

    // every second, all masked
    wr(2'd0, 8'hB0);
    tick_at(8'h07, 8'h44, 8'h01, 8'h17, 1'b1, "R8 all masked");
    // every second, only seconds masked
    wr(2'd3, 8'h25); wr(2'd2, 8'h12); wr(2'd1, 8'h15);
    tick_at(8'h01, 8'h02, 8'h03, 8'h04, 1'b1, "R8 odd mask pattern");
    tick_at(8'h59, 8'h59, 8'h23, 8'h31, 1'b1, "R8 odd mask pattern again");

    // simultaneous acknowledge and event
    @(negedge clk);
    tick = 1'b1; flag_rd = 1'b1;
    exp_q.push_back(1'b1); tag_q.push_back("R9 pulse with ack");
    @(negedge clk); tick = 1'b0; flag_rd = 1'b0;
    flag_chk(1'b1, "R10 set wins over ack");

    // no strobe: no pulse
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R9 quiet without tick", irq, 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule